// File: doc/BRIEF.md
# Flash Programming Scan Registers

This block provides the test-port data registers that open and drive an on-chip flash programming path. It sits behind a standard TAP controller and uses that controller's state indications: Capture-DR, Shift-DR, Update-DR and Run-Test/Idle. It also takes TCK, TDI and a two-bit register select decoded from the current instruction. It drives TDO, a programming-mode flag, a system reset request, and a 15-bit command bus with a one-cycle execute strobe toward a flash controller.

The block holds three scan registers. The first is a single-bit reset register whose content drives the system reset directly. The second is a 16-bit enable register, which grants programming mode only when it holds the expected signature at Update-DR. The third is a 15-bit command register that works as a pipeline: each scan shifts out the result of the command executed before it, while the next command shifts in. After an update, one pass through Run-Test/Idle issues a single execute strobe. The flash side returns a result with a valid flag, and the block keeps that result until a later capture reads it.

Top module: `jtag_prog_regs`

## Requirements
- R1: The register select `sel_i` uses these codes: 2'b00 none, 2'b01 reset register, 2'b10 enable register, 2'b11 command register. With the reset register selected, each Shift-DR cycle loads TDI into the reset bit. `sys_rst_o` follows that bit from the next clock edge, with no update stage in between.
- R2: `sys_rst_o` stays at its value until the reset register is shifted again. Capture, update, Run-Test/Idle and scans of other registers leave it unchanged.
- R3: Scans of the reset register do not change the programming mode or the command bus.
- R4: At Update-DR with the enable register selected, programming mode is set when the 16 shifted bits equal parameter `SIGNATURE` (default 16'hA370) and cleared otherwise. The first bit shifted in ends up in bit 0. Programming mode changes at no other time.
- R5: While programming mode is off, command updates leave `cmd_o` unchanged and Run-Test/Idle produces no execute strobe.
- R6: At Capture-DR with the command register selected, the register loads the most recent result delivered with `rsp_valid_i`. The result is 0 after reset and is held until the next valid response.
- R7: All registers shift toward TDO, which shows bit 0 of the selected register. The captured value therefore leaves least significant bit first. With no register selected, TDO is 0.
- R8: At Update-DR with the command register selected and programming mode on, the 15 shifted bits appear on `cmd_o` after the update clock edge and stay there until the next such update.
- R9: After a valid command update, the first Run-Test/Idle pass produces exactly one `exec_o` pulse of one cycle, however long the pass lasts. Later passes with no new update produce none.
- R10: With no register selected, capture, shift and update cycles change none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Data register select from instruction decode |
| capture_dr_i | input | 1 | TAP in Capture-DR |
| shift_dr_i | input | 1 | TAP in Shift-DR |
| update_dr_i | input | 1 | TAP in Update-DR |
| run_idle_i | input | 1 | TAP in Run-Test/Idle |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, bit 0 of selected register |
| prog_mode_o | output | 1 | Programming mode active |
| sys_rst_o | output | 1 | System reset request |
| cmd_o | output | 15 | Command bus to flash controller |
| exec_o | output | 1 | One-cycle execute strobe |
| rsp_data_i | input | 15 | Result from flash controller |
| rsp_valid_i | input | 1 | Result valid |

## Verification
The assertions check on every cycle the following. The reset output tracks the shifted bit and otherwise holds. Programming mode and the command bus move only at their own qualified updates. The execute strobe never lasts two cycles and never fires unless programming mode was on. Only the bench scenarios can show the end-to-end behaviour. These are the one-command-behind pipeline, in which each scan returns the previous command's result LSB first. They also include the signature match and mismatch, the single strobe per idle pass with none on a repeated pass, and the absence of effect from scans with no register selected or made outside programming mode.

// File: rtl/jtag_prog_pkg.sv
package jtag_prog_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_RST  = 2'b01,
    SEL_EN   = 2'b10,
    SEL_CMD  = 2'b11
  } dr_sel_e;

  localparam int unsigned SIG_W = 16;
  localparam int unsigned CMD_W = 15;
endpackage

// File: rtl/jp_reset_reg.sv
module jp_reset_reg (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic tdi_i,
  output logic bit_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)      bit_o <= 1'b0;
    else if (shift_i) bit_o <= tdi_i;
  end

  AST_RST_FOLLOWS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    shift_i |=> bit_o == $past(tdi_i)); // R1
  AST_RST_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !shift_i |=> $stable(bit_o)); // R2
endmodule

// File: rtl/jp_enable_reg.sv
module jp_enable_reg #(
  parameter int unsigned             W         = 16,
  parameter logic [W-1:0]            SIGNATURE = 16'hA370
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic update_i,
  input  logic tdi_i,
  output logic so_o,
  output logic prog_mode_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q        <= '0;
      prog_mode_o <= 1'b0;
    end else begin
      if (shift_i)  sr_q        <= {tdi_i, sr_q[W-1:1]};
      if (update_i) prog_mode_o <= (sr_q == SIGNATURE);
    end
  end

  assign so_o = sr_q[0];

  AST_MODE_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(prog_mode_o)); // R4
endmodule

// File: rtl/jp_cmd_reg.sv
module jp_cmd_reg #(
  parameter int unsigned W = 15
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         update_i,
  input  logic         run_idle_i,
  input  logic         prog_mode_i,
  input  logic         tdi_i,
  input  logic [W-1:0] rsp_data_i,
  input  logic         rsp_valid_i,
  output logic         so_o,
  output logic [W-1:0] cmd_o,
  output logic         exec_o
);
  logic [W-1:0] sr_q;
  logic [W-1:0] result_q;
  logic         armed_q;

  // result held apart from the scan path so a shift cannot corrupt it
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)          result_q <= '0;
    else if (rsp_valid_i) result_q <= rsp_data_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= result_q;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= '0;
      armed_q <= 1'b0;
      exec_o  <= 1'b0;
    end else begin
      exec_o <= 1'b0;
      if (update_i && prog_mode_i) begin
        cmd_o   <= sr_q;
        armed_q <= 1'b1;
      end else if (run_idle_i && armed_q && prog_mode_i) begin
        exec_o  <= 1'b1;
        armed_q <= 1'b0;
      end
    end
  end

  assign so_o = sr_q[0];

  AST_CMD_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(update_i && prog_mode_i) |=> $stable(cmd_o)); // R8
  AST_EXEC_SINGLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    exec_o |=> !exec_o); // R9
  AST_EXEC_GATED: assert property (@(posedge tck_i) disable iff (!rst_ni)
    exec_o |-> $past(prog_mode_i)); // R5
endmodule

// File: rtl/jtag_prog_regs.sv
module jtag_prog_regs
  import jtag_prog_pkg::*;
#(
  parameter logic [SIG_W-1:0] SIGNATURE = 16'hA370
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             capture_dr_i,
  input  logic             shift_dr_i,
  input  logic             update_dr_i,
  input  logic             run_idle_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  output logic             prog_mode_o,
  output logic             sys_rst_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             exec_o,
  input  logic [CMD_W-1:0] rsp_data_i,
  input  logic             rsp_valid_i
);
  dr_sel_e sel;
  logic    rst_so, en_so, cmd_so;

  assign sel = dr_sel_e'(sel_i);

  jp_reset_reg u_rst (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_dr_i && sel == SEL_RST),
    .tdi_i   (tdi_i),
    .bit_o   (rst_so)
  );

  jp_enable_reg #(.W(SIG_W), .SIGNATURE(SIGNATURE)) u_en (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .shift_i     (shift_dr_i && sel == SEL_EN),
    .update_i    (update_dr_i && sel == SEL_EN),
    .tdi_i       (tdi_i),
    .so_o        (en_so),
    .prog_mode_o (prog_mode_o)
  );

  jp_cmd_reg #(.W(CMD_W)) u_cmd (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .capture_i   (capture_dr_i && sel == SEL_CMD),
    .shift_i     (shift_dr_i && sel == SEL_CMD),
    .update_i    (update_dr_i && sel == SEL_CMD),
    .run_idle_i  (run_idle_i),
    .prog_mode_i (prog_mode_o),
    .tdi_i       (tdi_i),
    .rsp_data_i  (rsp_data_i),
    .rsp_valid_i (rsp_valid_i),
    .so_o        (cmd_so),
    .cmd_o       (cmd_o),
    .exec_o      (exec_o)
  );

  assign sys_rst_o = rst_so;

  always_comb begin
    case (sel)
      SEL_RST: tdo_o = rst_so;
      SEL_EN:  tdo_o = en_so;
      SEL_CMD: tdo_o = cmd_so;
      default: tdo_o = 1'b0;
    endcase
  end
endmodule

// File: tb/jtag_prog_regs_test.sv
module jtag_prog_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SIG = 16'hA370;

  logic        tck = 0, rst_ni = 0;
  logic [1:0]  sel_i = 0;
  logic        capture_dr_i = 0, shift_dr_i = 0, update_dr_i = 0, run_idle_i = 0, tdi_i = 0;
  logic        tdo_o, prog_mode_o, sys_rst_o, exec_o;
  logic [14:0] cmd_o;
  logic [14:0] rsp_data_i = 0;
  logic        rsp_valid_i = 0;

  int checks = 0, errors = 0;

  jtag_prog_regs #(.SIGNATURE(SIG)) uut (
    .tck_i(tck), .rst_ni(rst_ni), .sel_i(sel_i),
    .capture_dr_i(capture_dr_i), .shift_dr_i(shift_dr_i), .update_dr_i(update_dr_i),
    .run_idle_i(run_idle_i), .tdi_i(tdi_i), .tdo_o(tdo_o), .prog_mode_o(prog_mode_o),
    .sys_rst_o(sys_rst_o), .cmd_o(cmd_o), .exec_o(exec_o),
    .rsp_data_i(rsp_data_i), .rsp_valid_i(rsp_valid_i)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  function automatic logic [14:0] flash_result(logic [14:0] c);
    return {c[6:0], c[14:7]} ^ 15'h1D3B;
  endfunction

  // flash responder: one-cycle result after each strobe
  always @(negedge tck) begin
    if (exec_o) begin
      rsp_valid_i = 1'b1;
      rsp_data_i  = flash_result(cmd_o);
    end else begin
      rsp_valid_i = 1'b0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [1:0] s, input logic [15:0] d, input int n,
                      output logic [15:0] q);
    q = '0;
    @(negedge tck); sel_i = s; capture_dr_i = 1;
    @(negedge tck); capture_dr_i = 0;
    for (int i = 0; i < n; i++) begin
      shift_dr_i = 1; tdi_i = d[i];
      #1 q[i] = tdo_o;
      @(negedge tck);
    end
    shift_dr_i = 0; update_dr_i = 1;
    @(negedge tck); update_dr_i = 0;
  endtask

  task automatic idle(input int k, output int pulses);
    pulses = 0;
    for (int i = 0; i < k; i++) begin
      run_idle_i = 1;
      @(negedge tck);
      if (exec_o) pulses++;
    end
    run_idle_i = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge tck);
      if (exec_o) pulses++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] q;
    logic [14:0] c, last_res;
    int p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge tck);
    rst_ni = 1;
    @(negedge tck);
    chk("R1 reset sys_rst", sys_rst_o, 0);
    chk("R4 reset prog_mode", prog_mode_o, 0);
    chk("R8 reset cmd", cmd_o, 0);
    chk("R9 reset exec", exec_o, 0);
    chk("R7 tdo none", tdo_o, 0);

    // R5: commands ignored outside programming mode
    scan(2'b11, 16'h1234, 15, q);
    chk("R6 first capture zero", q[14:0], 0);
    chk("R5 cmd unchanged", cmd_o, 0);
    idle(2, p);
    chk("R5 no exec", p, 0);

    // R4: wrong then right signature
    scan(2'b10, SIG ^ 16'h0100, 16, q);
    chk("R4 wrong sig", prog_mode_o, 0);
    scan(2'b10, SIG, 16, q);
    chk("R4 right sig", prog_mode_o, 1);
    scan(2'b10, SIG, 16, q);
    chk("R7 enable reg shifts out prior content", q, SIG);

    // R1 R2 R3: reset register
    scan(2'b01, 16'h0001, 1, q);
    chk("R1 sys_rst set", sys_rst_o, 1);
    chk("R3 prog_mode kept", prog_mode_o, 1);
    idle(3, p);
    chk("R2 sys_rst held over idle", sys_rst_o, 1);
    scan(2'b01, 16'h0000, 1, q);
    chk("R7 reset reg out", q[0], 1);
    chk("R1 sys_rst cleared", sys_rst_o, 0);

    // R6 R7 R8 R9: pipelined commands, random
    last_res = '0;
    for (int i = 0; i < 24; i++) begin
      c = 15'($urandom);
      scan(2'b11, {1'b0, c}, 15, q);
      chk("R6 R7 captured previous result", q[14:0], last_res);
      chk("R8 cmd driven", cmd_o, c);
      chk("R2 sys_rst stays", sys_rst_o, 0);
      if ($urandom % 4 != 0) begin
        idle(1 + int'($urandom % 4), p);
        chk("R9 one exec", p, 1);
        last_res = flash_result(c);
        if (i % 5 == 0) begin
          idle(2, p);
          chk("R9 no repeat exec", p, 0);
        end
      end
    end

    // R10: no register selected
    c = cmd_o;
    scan(2'b00, 16'hFFFF, 16, q);
    chk("R10 tdo zero", q, 0);
    chk("R10 cmd unchanged", cmd_o, c);
    chk("R10 sys_rst unchanged", sys_rst_o, 0);
    chk("R10 mode unchanged", prog_mode_o, 1);

    // R3: reset scan does not disturb command bus
    scan(2'b01, 16'h0001, 1, q);
    chk("R3 cmd kept", cmd_o, c);
    scan(2'b01, 16'h0000, 1, q);

    // R4: mismatch clears mode, then R5 gating again
    scan(2'b10, 16'h0000, 16, q);
    chk("R4 mode cleared", prog_mode_o, 0);
    scan(2'b11, 16'h7ABC, 15, q);
    chk("R5 cmd frozen", cmd_o, c);
    idle(2, p);
    chk("R5 no exec off", p, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule